// File: doc/BRIEF.md
# Interrupt Claim/Complete Controller

This block collects level-sensitive interrupt requests from a set of sources and presents them to a single target. Each source has a small priority value, an enable bit for the target and a gateway. The gateway records that a request is waiting (pending) and that the target is handling it (in service). The target sees one interrupt line. It is raised when a waiting, enabled request has a priority above the target's threshold.

The target takes work through a claim/complete port. A claim strobe returns, in the same cycle, the identifier of the best candidate. At the clock edge that closes that cycle, the candidate's pending state is cleared and it is marked in service. A completion write with an identifier releases the source so that it can request again. A completion is accepted only while the source's enable bit is set. A mode input selects an auto-mask variant, in which a claim also clears the claimed source's enable bit. In that mode, software that completes without first re-enabling leaves the source stuck in service.

Sources are numbered 1 to NUM_SRC. Input bit i of the level vector belongs to identifier i+1. Identifier 0 means "nothing".

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, every source is idle, disabled and at priority 0, and the threshold is 0. irq_out is low and a claim returns 0.
- R2: While claim_rd is high, claim_id is the identifier of the candidate with the greatest priority. A candidate is a source that is pending, enabled and at priority 1 or more. Among equal priorities the lowest identifier wins, and input bit i maps to identifier i+1.
- R3: claim_id is 0 when there is no candidate, and it is always 0 while claim_rd is low.
- R4: A source whose level is high while it is neither pending nor in service becomes pending at the next clock edge. A claim clears the pending bit of the returned source and marks it in service at the edge that ends the claim cycle.
- R5: While a source is in service it does not become pending, it does not contribute to irq_out, and a claim does not return it.
- R6: A completion that is accepted clears in-service. If the level is still high, the source becomes pending again at the edge after the completion edge, and irq_out can rise from then on.
- R7: A completion whose identifier names a source with its enable bit at 0 is ignored. The source stays in service, even if it is enabled again later.
- R8: With automask_mode high (auto-mask), a claim also clears the claimed source's enable bit, and this overrides an enable write in the same cycle. With automask_mode low (standard), a claim leaves the enable bit unchanged.
- R9: A completion with identifier 0, or with an identifier above NUM_SRC, has no effect.
- R10: irq_out is high exactly when some pending, enabled source that is not in service has a priority strictly greater than the threshold. The threshold does not affect what a claim returns.
- R11: When a completion and a claim happen in the same cycle, the completion is applied first. A source completed in that cycle with its level still high can be returned by the claim, and it stays in service.
- R12: A source at priority 0 is never returned by a claim and never raises irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Level request of each source (bit i is identifier i+1) |
| automask_mode | input | 1 | 1 = claim also clears the enable bit, 0 = standard |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | ID_W | Identifier whose priority is written |
| prio_wdata | input | PRIO_W | New priority value |
| en_we | input | 1 | Enable write strobe |
| en_sel | input | ID_W | Identifier whose enable bit is written |
| en_wdata | input | 1 | New enable value |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | PRIO_W | New threshold value |
| claim_rd | input | 1 | Claim strobe |
| claim_id | output | ID_W | Claimed identifier, valid in the claim cycle |
| cmpl_we | input | 1 | Completion write strobe |
| cmpl_id | input | ID_W | Identifier being completed |
| irq_out | output | 1 | Interrupt request to the target |

## Verification
A corrupted gateway bit shows at the ports within one or two cycles. A stale in-service flag keeps irq_out low, and the next claim returns 0 or the wrong identifier. A lost pending bit shows the same way. A pending bit set too early raises irq_out one edge ahead of the completion-plus-one-edge timing. An enable bit that is wrongly cleared, or wrongly kept, in either mode only shows one completion later: the source either recovers or stays silent for good. For that reason, every completion in the bench is followed by watching irq_out for several cycles and then issuing a claim. The bench runs a cycle model of the requirements next to the design. It compares every claim and the interrupt line on every edge, over many priority patterns and thresholds.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Claim behaviour selected by the mode input.
    typedef enum logic {
        CLAIM_STD      = 1'b0,
        CLAIM_AUTOMASK = 1'b1
    } claim_mode_e;

    // Per-source gateway state.
    typedef struct packed {
        logic pend;
        logic insvc;
    } gw_state_t;

    // Bits needed to hold identifiers 0..n.
    function automatic int id_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    input  logic      claim_hit,
    input  logic      cmpl_ok,
    output gw_state_t st_q,
    output logic      claimable
);

    // A completion accepted this cycle lets a still-high level be claimed
    // at once; otherwise only the stored pending bit counts.
    assign claimable = st_q.pend | (cmpl_ok & level);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (claim_hit) begin
            st_q.pend  <= 1'b0;
            st_q.insvc <= 1'b1;
        end else begin
            if (cmpl_ok) begin
                st_q.insvc <= 1'b0;
            end
            if (level && !st_q.insvc) begin
                st_q.pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        prio_we,
    input  logic [ID_W-1:0]             prio_sel,
    input  logic [PRIO_W-1:0]           prio_wdata,
    input  logic                        en_we,
    input  logic [ID_W-1:0]             en_sel,
    input  logic                        en_wdata,
    input  logic                        thr_we,
    input  logic [PRIO_W-1:0]           thr_wdata,
    input  logic [NUM_SRC-1:0]          mask_clr,
    output logic [NUM_SRC*PRIO_W-1:0]   prio_flat,
    output logic [NUM_SRC-1:0]          en_q,
    output logic [PRIO_W-1:0]           thr_q
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam logic [ID_W-1:0] MY_ID = ID_W'(g + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                prio_flat[g*PRIO_W +: PRIO_W] <= '0;
            end else if (prio_we && prio_sel == MY_ID) begin
                prio_flat[g*PRIO_W +: PRIO_W] <= prio_wdata;
            end
        end

        // Auto-mask clearing outranks a software enable write.
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[g] <= 1'b0;
            end else if (mask_clr[g]) begin
                en_q[g] <= 1'b0;
            end else if (en_we && en_sel == MY_ID) begin
                en_q[g] <= en_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_wdata;
        end
    end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 4
) (
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [ID_W-1:0]           win_idx
);

    logic [PRIO_W-1:0] best_prio;

    // Linear scan: strict compare keeps the lowest index on ties and
    // starting from zero drops priority-0 sources.
    always_comb begin
        found     = 1'b0;
        win_idx   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && prio_flat[i*PRIO_W +: PRIO_W] > best_prio) begin
                found     = 1'b1;
                win_idx   = ID_W'(i);
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int ID_W   = id_bits(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               automask_mode,
    input  logic               prio_we,
    input  logic [ID_W-1:0]    prio_sel,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               en_we,
    input  logic [ID_W-1:0]    en_sel,
    input  logic               en_wdata,
    input  logic               thr_we,
    input  logic [PRIO_W-1:0]  thr_wdata,
    input  logic               claim_rd,
    output logic [ID_W-1:0]    claim_id,
    input  logic               cmpl_we,
    input  logic [ID_W-1:0]    cmpl_id,
    output logic               irq_out
);

    claim_mode_e                mode;
    gw_state_t                  gw_st [NUM_SRC];
    logic [NUM_SRC-1:0]         pend_q, insvc_q, claimable;
    logic [NUM_SRC-1:0]         claim_hit, cmpl_ok, mask_clr;
    logic [NUM_SRC-1:0]         claim_cand, above_thr;
    logic [NUM_SRC-1:0]         en_q;
    logic [NUM_SRC*PRIO_W-1:0]  prio_flat;
    logic [PRIO_W-1:0]          thr_q;
    logic                       c_found;
    logic [ID_W-1:0]            c_idx;

    assign mode = claim_mode_e'(automask_mode);

    irqc_cfg #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .prio_we    (prio_we),
        .prio_sel   (prio_sel),
        .prio_wdata (prio_wdata),
        .en_we      (en_we),
        .en_sel     (en_sel),
        .en_wdata   (en_wdata),
        .thr_we     (thr_we),
        .thr_wdata  (thr_wdata),
        .mask_clr   (mask_clr),
        .prio_flat  (prio_flat),
        .en_q       (en_q),
        .thr_q      (thr_q)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gw
        localparam logic [ID_W-1:0] MY_ID  = ID_W'(g + 1);
        localparam logic [ID_W-1:0] MY_IDX = ID_W'(g);

        // Completion takes effect only for a currently enabled source;
        // identifier 0 and out-of-range values match no source.
        assign cmpl_ok[g]   = cmpl_we && (cmpl_id == MY_ID) && en_q[g];
        assign claim_hit[g] = claim_rd && c_found && (c_idx == MY_IDX);
        assign mask_clr[g]  = (mode == CLAIM_AUTOMASK) && claim_hit[g];

        irqc_gateway u_gw (
            .clk       (clk),
            .rst       (rst),
            .level     (src_level[g]),
            .claim_hit (claim_hit[g]),
            .cmpl_ok   (cmpl_ok[g]),
            .st_q      (gw_st[g]),
            .claimable (claimable[g])
        );

        assign pend_q[g]  = gw_st[g].pend;
        assign insvc_q[g] = gw_st[g].insvc;

        assign above_thr[g] = pend_q[g] && en_q[g] && !insvc_q[g]
                              && (prio_flat[g*PRIO_W +: PRIO_W] > thr_q);
    end

    assign claim_cand = claimable & en_q;

    irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_claim_arb (
        .cand      (claim_cand),
        .prio_flat (prio_flat),
        .found     (c_found),
        .win_idx   (c_idx)
    );

    assign claim_id = (claim_rd && c_found) ? c_idx + ID_W'(1) : '0;
    assign irq_out  = |above_thr;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = 8,
    parameter int ID_W    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               automask_mode,
    input logic               claim_rd,
    input logic [ID_W-1:0]    claim_id,
    input logic               cmpl_we,
    input logic [ID_W-1:0]    cmpl_id,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] insvc_q
);

    assert_claim_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        claim_rd |-> claim_id <= ID_W'(NUM_SRC));

    assert_idle_claim_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !claim_rd |-> claim_id == '0);

    assert_irq_is_claimable_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_out && claim_rd) |-> claim_id != '0);

    assert_bad_cmpl_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (cmpl_we && !claim_rd && (cmpl_id == '0 || cmpl_id > ID_W'(NUM_SRC)))
        |=> $stable(insvc_q));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        localparam logic [ID_W-1:0] MY_ID = ID_W'(g + 1);

        assert_claim_moves_to_svc_R4: assert property (@(posedge clk) disable iff (rst)
            (claim_rd && claim_id == MY_ID) |=> (!pend_q[g] && insvc_q[g]));

        assert_svc_excludes_pend_R5: assert property (@(posedge clk) disable iff (rst)
            insvc_q[g] |-> !pend_q[g]);

        assert_disabled_cmpl_ignored_R7: assert property (@(posedge clk) disable iff (rst)
            (cmpl_we && cmpl_id == MY_ID && !en_q[g] && insvc_q[g]) |=> insvc_q[g]);

        assert_automask_clears_en_R8: assert property (@(posedge clk) disable iff (rst)
            (automask_mode && claim_rd && claim_id == MY_ID) |=> !en_q[g]);
    end

endmodule

bind irq_claim_ctrl irqc_checker #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .automask_mode (automask_mode),
    .claim_rd      (claim_rd),
    .claim_id      (claim_id),
    .cmpl_we       (cmpl_we),
    .cmpl_id       (cmpl_id),
    .irq_out       (irq_out),
    .en_q          (en_q),
    .pend_q        (pend_q),
    .insvc_q       (insvc_q)
);

// File: tb/tb_irq_claim_ctrl.sv
module tb_irq_claim_ctrl;

    localparam int N       = 8;
    localparam int PW      = 3;
    localparam int IW      = 4;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_level = '0;
    logic          automask_mode = 1'b0;
    logic          prio_we = 1'b0;
    logic [IW-1:0] prio_sel = '0;
    logic [PW-1:0] prio_wdata = '0;
    logic          en_we = 1'b0;
    logic [IW-1:0] en_sel = '0;
    logic          en_wdata = 1'b0;
    logic          thr_we = 1'b0;
    logic [PW-1:0] thr_wdata = '0;
    logic          claim_rd = 1'b0;
    logic [IW-1:0] claim_id;
    logic          cmpl_we = 1'b0;
    logic [IW-1:0] cmpl_id = '0;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Requirement model state
    int m_pr   [N];
    bit m_en   [N];
    bit m_pend [N];
    bit m_ins  [N];
    int m_thr = 0;

    irq_claim_ctrl #(.NUM_SRC(N), .PRIO_W(PW)) dut (
        .clk           (clk),
        .rst           (rst),
        .src_level     (src_level),
        .automask_mode (automask_mode),
        .prio_we       (prio_we),
        .prio_sel      (prio_sel),
        .prio_wdata    (prio_wdata),
        .en_we         (en_we),
        .en_sel        (en_sel),
        .en_wdata      (en_wdata),
        .thr_we        (thr_we),
        .thr_wdata     (thr_wdata),
        .claim_rd      (claim_rd),
        .claim_id      (claim_id),
        .cmpl_we       (cmpl_we),
        .cmpl_id       (cmpl_id),
        .irq_out       (irq_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit m_cmpl_ok(input int i);
        return cmpl_we && (int'(cmpl_id) == i + 1) && m_en[i];
    endfunction

    // R2/R11: best candidate under the current inputs.
    function automatic int exp_winner();
        int best = 0;
        int bp   = 0;
        for (int i = 0; i < N; i++) begin
            bit cp;
            cp = m_pend[i] | (m_cmpl_ok(i) & src_level[i]);
            if (cp && m_en[i] && m_pr[i] > bp) begin
                bp   = m_pr[i];
                best = i + 1;
            end
        end
        return best;
    endfunction

    // R10
    function automatic int exp_irq();
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && m_en[i] && !m_ins[i] && m_pr[i] > m_thr) return 1;
        end
        return 0;
    endfunction

    // One clock edge: update the model from the driven inputs, then compare irq_out.
    task automatic clk_edge();
        int w;
        bit np [N];
        bit ni [N];
        bit ne [N];
        int npr [N];
        int nthr;
        w = claim_rd ? exp_winner() : 0;
        for (int i = 0; i < N; i++) begin
            bit ok;
            bit hit;
            ok  = m_cmpl_ok(i);
            hit = (w == i + 1);
            ni[i]  = hit ? 1'b1 : (ok ? 1'b0 : m_ins[i]);
            np[i]  = hit ? 1'b0 : (m_pend[i] | (src_level[i] & ~m_ins[i]));
            ne[i]  = (automask_mode && hit) ? 1'b0 :
                     ((en_we && int'(en_sel) == i + 1) ? en_wdata : m_en[i]);
            npr[i] = (prio_we && int'(prio_sel) == i + 1) ? int'(prio_wdata) : m_pr[i];
        end
        nthr = thr_we ? int'(thr_wdata) : m_thr;
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            m_pend[i] = np[i];
            m_ins[i]  = ni[i];
            m_en[i]   = ne[i];
            m_pr[i]   = npr[i];
        end
        m_thr = nthr;
        #1;
        chk("R10 irq_out vs model", int'(irq_out), exp_irq());
    endtask

    task automatic set_prio(input int id, input int p);
        prio_we = 1'b1; prio_sel = IW'(id); prio_wdata = PW'(p);
        clk_edge();
        prio_we = 1'b0;
    endtask

    task automatic set_en(input int id, input bit v);
        en_we = 1'b1; en_sel = IW'(id); en_wdata = v;
        clk_edge();
        en_we = 1'b0;
    endtask

    task automatic set_thr(input int t);
        thr_we = 1'b1; thr_wdata = PW'(t);
        clk_edge();
        thr_we = 1'b0;
    endtask

    task automatic complete(input int id);
        cmpl_we = 1'b1; cmpl_id = IW'(id);
        clk_edge();
        cmpl_we = 1'b0; cmpl_id = '0;
    endtask

    task automatic claim_expect(input int exp, input string req);
        claim_rd = 1'b1;
        #1;
        chk(req, int'(claim_id), exp);
        clk_edge();
        claim_rd = 1'b0;
    endtask

    // Claim checked against the model's winner.
    task automatic claim_model(input string req);
        int e;
        claim_rd = 1'b1;
        #1;
        e = exp_winner();
        chk(req, int'(claim_id), e);
        clk_edge();
        claim_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) clk_edge();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_pr[i] = 0; m_en[i] = 0; m_pend[i] = 0; m_ins[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        chk("R1 irq_out after reset", int'(irq_out), 0);
        claim_expect(0, "R1 claim after reset");
        src_level[2] = 1'b1;           // level alone, disabled, priority 0
        idle(2);
        chk("R1 disabled source quiet", int'(irq_out), 0);
        claim_expect(0, "R3 no candidate");

        // R2/R4: basic claim of identifier 3
        set_prio(3, 5);
        set_en(3, 1'b1);
        idle(1);
        chk("R4 pending raises irq", int'(irq_out), 1);
        #1;
        chk("R3 claim_id zero without claim_rd", int'(claim_id), 0);
        claim_expect(3, "R2 single source claim");
        chk("R4 claim clears pending", int'(irq_out), 0);
        claim_expect(0, "R5 in-service not reclaimed");
        idle(3);
        chk("R5 in service keeps irq low", int'(irq_out), 0);

        // R6 timing (standard mode also keeps enable: R8)
        complete(3);
        chk("R6 no irq at completion edge", int'(irq_out), 0);
        idle(1);
        chk("R6 pending again one edge later", int'(irq_out), 1);
        claim_expect(3, "R6 reclaim after completion");

        // R7: completion to a disabled source
        set_en(3, 1'b0);
        complete(3);
        set_en(3, 1'b1);
        idle(3);
        chk("R7 ignored completion keeps in service", int'(irq_out), 0);
        claim_expect(0, "R7 still in service");
        complete(3);
        idle(1);
        chk("R7 enabled completion accepted", int'(irq_out), 1);

        // R9: bad identifiers
        claim_expect(3, "R9 setup claim");
        complete(0);
        complete(N + 1);
        complete(15);
        idle(2);
        chk("R9 bad ids ignored irq", int'(irq_out), 0);
        claim_expect(0, "R9 bad ids ignored claim");
        complete(3);
        idle(1);
        chk("R9 valid completion after", int'(irq_out), 1);

        // R11: completion and claim in the same cycle
        claim_expect(3, "R11 setup claim");
        cmpl_we = 1'b1; cmpl_id = IW'(3); claim_rd = 1'b1;
        #1;
        chk("R11 same-cycle reclaim", int'(claim_id), 3);
        clk_edge();
        cmpl_we = 1'b0; cmpl_id = '0; claim_rd = 1'b0;
        idle(1);
        chk("R11 stays in service", int'(irq_out), 0);
        claim_expect(0, "R11 nothing else claimable");
        complete(3);
        idle(1);
        chk("R11 recovers", int'(irq_out), 1);

        // R8: auto-mask mode deadlock and recovery
        automask_mode = 1'b1;
        claim_expect(3, "R8 automask claim");
        automask_mode = 1'b0;
        complete(3);
        idle(3);
        chk("R8 masked completion ignored", int'(irq_out), 0);
        claim_expect(0, "R8 source stuck in service");
        set_en(3, 1'b1);
        complete(3);
        idle(1);
        chk("R8 re-enable then complete", int'(irq_out), 1);
        // R8: mask wins over a same-cycle enable write
        automask_mode = 1'b1;
        en_we = 1'b1; en_sel = IW'(3); en_wdata = 1'b1;
        claim_expect(3, "R8 claim with enable write");
        en_we = 1'b0;
        automask_mode = 1'b0;
        complete(3);
        idle(2);
        chk("R8 mask overrides enable write", int'(irq_out), 0);
        set_en(3, 1'b1);
        complete(3);
        idle(1);

        // R12: priority 0 source
        set_prio(5, 0);
        set_en(5, 1'b1);
        src_level[4] = 1'b1;
        idle(2);
        claim_expect(3, "R12 prio-0 source skipped");
        claim_expect(0, "R12 prio-0 never claimed");
        chk("R12 prio-0 no irq", int'(irq_out), 0);
        complete(3);
        idle(1);

        // R10: threshold sweep with identifier 3 pending
        for (int p = 1; p < 8; p++) begin
            set_prio(3, p);
            for (int t = 0; t < 8; t++) begin
                set_thr(t);
                chk("R10 threshold compare", int'(irq_out), (p > t) ? 1 : 0);
            end
        end
        chk("R10 irq low at equal priority", int'(irq_out), 0);
        claim_expect(3, "R10 claim ignores threshold");
        complete(3);
        set_thr(0);

        // R2: priority pattern sweep, all sources enabled and requesting
        src_level = '1;
        for (int i = 1; i <= N; i++) set_en(i, 1'b1);
        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < N; i++) set_prio(i + 1, (i * 5 + k * 3) % 8);
            set_thr(k % 5);
            idle(1);
            for (int j = 0; j <= N; j++) claim_model("R2 arbitration sweep");
            for (int i = 1; i <= N; i++) complete(i);
            idle(2);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule